// File: doc/BRIEF.md
# Keyed Register Write Gate

This block sits between a register bus and a peripheral's register file. It stops write strobes aimed at the guarded registers until software has loaded two 32-bit unlock keys into two dedicated key holders, in a fixed order. Storing any other value in either key holder closes the gate again. The usual way to re-lock is to write zero to both holders.

Reads are never held back. They pass straight through from the register file, except at the two key holder addresses, where the block returns the value last written there. Registers outside the guarded set accept writes whatever the lock state. The address and data of a write are forwarded unchanged beside the filtered strobe, so the register file decodes the address as it would without the gate.

Top module: `keyed_write_gate`

## Requirements
- R1: After reset the gate is closed and both key holders read as zero.
- R2: Key holder A is the word at byte offset 0x6C and key holder B the word at 0x70 (the low two address bits are ignored). A write there stores the data, readable at the same offset from the next cycle. A write to a key holder never raises `rf_we`.
- R3: Writing 0x95A4F1E0 to holder B while holder A already holds 0x83E70B13 opens the gate from the next cycle on.
- R4: Order matters. Writing the correct B key while holder A does not hold its key leaves the gate closed, and writing the correct A key afterwards does not open it either.
- R5: Writing any value other than its own key to either holder closes the gate from the next cycle on. Writing zero to both holders therefore leaves it closed.
- R6: While the gate is closed, a write to a guarded word keeps `rf_we` low.
- R7: While the gate is open, a write to a guarded word raises `rf_we` in the same cycle, with `rf_addr` and `rf_wdata` equal to the bus address and data.
- R8: A write to a word that is neither guarded nor a key holder raises `rf_we` in the same cycle whatever the lock state, and does not change the lock state.
- R9: The guarded word offsets are: 0x00–0x18, 0x20–0x34, 0x44, 0x48, 0x54, 0x60–0x68 and 0x80–0x98. Every other offset except the key holders is unguarded.
- R10: For any address other than a key holder, `bus_rdata` equals `rf_rdata` in the same cycle, whether the gate is open or closed.
- R11: While the gate is open, writing the correct key again to either holder leaves it open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Write strobe from the bus |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data returned to the bus |
| rf_we | output | 1 | Filtered write strobe to the register file |
| rf_addr | output | 8 | Address forwarded to the register file |
| rf_wdata | output | 32 | Write data forwarded to the register file |
| rf_rdata | input | 32 | Read data from the register file |

## Verification
The assertions assume that `bus_we`, `bus_addr` and `bus_wdata` carry known values at every rising edge once reset is released, and that each write lasts exactly one cycle. The bench drives every input from time zero. It changes inputs only on falling edges and pulls the strobe low right after the rising edge that takes each write. Key data is drawn from a mix of the two correct keys, zero and random words. That mix makes both the opening and closing sequences occur often under random stimulus.

// File: rtl/kwg_pkg.sv
package kwg_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        ACC_PLAIN   = 2'd0,
        ACC_GUARDED = 2'd1,
        ACC_KEYA    = 2'd2,
        ACC_KEYB    = 2'd3
    } acc_class_t;

    typedef struct packed {
        logic [WORD_W-1:0] key_a;
        logic [WORD_W-1:0] key_b;
        logic              open;
    } gate_state_t;

    // Guarded word indices (byte offset / 4).
    function automatic logic word_is_guarded(input int unsigned w);
        logic g;
        g = 1'b0;
        if (w <= 6)                 g = 1'b1;
        if (w >= 8  && w <= 13)     g = 1'b1;
        if (w == 17 || w == 18)     g = 1'b1;
        if (w == 21)                g = 1'b1;
        if (w >= 24 && w <= 26)     g = 1'b1;
        if (w >= 32 && w <= 38)     g = 1'b1;
        return g;
    endfunction

endpackage

// File: rtl/kwg_addr_class.sv
module kwg_addr_class
    import kwg_pkg::*;
#(
    parameter int          ADDR_W  = 8,
    parameter logic [7:0]  KEYA_OFS = 8'h6C,
    parameter logic [7:0]  KEYB_OFS = 8'h70
) (
    input  logic [ADDR_W-3:0] word_idx,
    output acc_class_t        cls
);
    localparam int IDX_W = ADDR_W - 2;
    localparam logic [IDX_W-1:0] KEYA_IDX = IDX_W'(KEYA_OFS >> 2);
    localparam logic [IDX_W-1:0] KEYB_IDX = IDX_W'(KEYB_OFS >> 2);

    always_comb begin
        if (word_idx == KEYA_IDX)
            cls = ACC_KEYA;
        else if (word_idx == KEYB_IDX)
            cls = ACC_KEYB;
        else if (word_is_guarded(32'(word_idx)))
            cls = ACC_GUARDED;
        else
            cls = ACC_PLAIN;
    end
endmodule

// File: rtl/kwg_key_lock.sv
module kwg_key_lock
    import kwg_pkg::*;
#(
    parameter logic [WORD_W-1:0] KEYA_VAL = 32'h83E7_0B13,
    parameter logic [WORD_W-1:0] KEYB_VAL = 32'h95A4_F1E0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  acc_class_t        cls,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] key_a_q,
    output logic [WORD_W-1:0] key_b_q,
    output logic              open_q
);
    gate_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && cls == ACC_KEYA) begin
            st_d.key_a = wdata;
            if (wdata != KEYA_VAL)
                st_d.open = 1'b0;
        end else if (wr_en && cls == ACC_KEYB) begin
            st_d.key_b = wdata;
            if (wdata != KEYB_VAL)
                st_d.open = 1'b0;
            else if (st_q.key_a == KEYA_VAL)
                st_d.open = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign key_a_q = st_q.key_a;
    assign key_b_q = st_q.key_b;
    assign open_q  = st_q.open;

    assert_open_needs_keys_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.open) |-> $past(wr_en && cls == ACC_KEYB && wdata == KEYB_VAL
                                   && st_q.key_a == KEYA_VAL));

    assert_bad_key_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ((cls == ACC_KEYA && wdata != KEYA_VAL) ||
                   (cls == ACC_KEYB && wdata != KEYB_VAL))) |=> !st_q.open);

    assert_key_stored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cls == ACC_KEYA) |=> (st_q.key_a == $past(wdata)));

    assert_other_write_keeps_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (cls == ACC_PLAIN || cls == ACC_GUARDED)) |=> $stable(st_q.open));
endmodule

// File: rtl/kwg_strobe_filter.sv
module kwg_strobe_filter
    import kwg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    input  acc_class_t        cls,
    input  logic              gate_open,
    input  logic [WORD_W-1:0] key_a,
    input  logic [WORD_W-1:0] key_b,
    input  logic [WORD_W-1:0] rf_rdata,
    output logic              rf_we,
    output logic [ADDR_W-1:0] rf_addr,
    output logic [WORD_W-1:0] rf_wdata,
    output logic [WORD_W-1:0] bus_rdata
);
    always_comb begin
        unique case (cls)
            ACC_PLAIN:   rf_we = bus_we;
            ACC_GUARDED: rf_we = bus_we && gate_open;
            default:     rf_we = 1'b0;
        endcase
    end

    always_comb begin
        unique case (cls)
            ACC_KEYA: bus_rdata = key_a;
            ACC_KEYB: bus_rdata = key_b;
            default:  bus_rdata = rf_rdata;
        endcase
    end

    assign rf_addr  = bus_addr;
    assign rf_wdata = bus_wdata;
endmodule

// File: rtl/keyed_write_gate.sv
module keyed_write_gate
    import kwg_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [7:0]        KEYA_OFS = 8'h6C,
    parameter logic [7:0]        KEYB_OFS = 8'h70,
    parameter logic [WORD_W-1:0] KEYA_VAL = 32'h83E7_0B13,
    parameter logic [WORD_W-1:0] KEYB_VAL = 32'h95A4_F1E0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              rf_we,
    output logic [ADDR_W-1:0] rf_addr,
    output logic [WORD_W-1:0] rf_wdata,
    input  logic [WORD_W-1:0] rf_rdata
);
    acc_class_t        cls;
    logic              gate_open;
    logic [WORD_W-1:0] key_a, key_b;

    kwg_addr_class #(
        .ADDR_W(ADDR_W), .KEYA_OFS(KEYA_OFS), .KEYB_OFS(KEYB_OFS)
    ) u_class (
        .word_idx(bus_addr[ADDR_W-1:2]),
        .cls     (cls)
    );

    kwg_key_lock #(
        .KEYA_VAL(KEYA_VAL), .KEYB_VAL(KEYB_VAL)
    ) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_we),
        .cls    (cls),
        .wdata  (bus_wdata),
        .key_a_q(key_a),
        .key_b_q(key_b),
        .open_q (gate_open)
    );

    kwg_strobe_filter #(
        .ADDR_W(ADDR_W)
    ) u_filter (
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .cls      (cls),
        .gate_open(gate_open),
        .key_a    (key_a),
        .key_b    (key_b),
        .rf_rdata (rf_rdata),
        .rf_we    (rf_we),
        .rf_addr  (rf_addr),
        .rf_wdata (rf_wdata),
        .bus_rdata(bus_rdata)
    );

    assert_closed_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && cls == ACC_GUARDED && !gate_open) |-> !rf_we);

    assert_open_forwards_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && cls == ACC_GUARDED && gate_open) |-> (rf_we && rf_wdata == bus_wdata));

    assert_key_no_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == ACC_KEYA || cls == ACC_KEYB) |-> !rf_we);

    assert_plain_passes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && cls == ACC_PLAIN) |-> rf_we);

    assert_read_passes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == ACC_PLAIN || cls == ACC_GUARDED) |-> (bus_rdata == rf_rdata));
endmodule

// File: tb/tb_keyed_write_gate.sv
module tb_keyed_write_gate;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] KA = 32'h83E7_0B13;
    localparam logic [31:0] KB = 32'h95A4_F1E0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        rf_we;
    logic [7:0]  rf_addr;
    logic [31:0] rf_wdata;
    logic [31:0] rf_rdata = 32'h0;

    int checks = 0;
    int errors = 0;
    logic [31:0] m_ka = 0, m_kb = 0;
    logic        m_open = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    keyed_write_gate dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rf_we(rf_we),
        .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
    );

    // 0 plain, 1 guarded, 2 key A, 3 key B  (R9, R2)
    function automatic int classify(input logic [7:0] a);
        int w;
        w = int'(a[7:2]);
        if (w == 27) return 2;
        if (w == 28) return 3;
        if ((w >= 0 && w <= 6) || (w >= 8 && w <= 13) || w == 17 || w == 18 ||
            w == 21 || (w >= 24 && w <= 26) || (w >= 32 && w <= 38)) return 1;
        return 0;
    endfunction

    function automatic logic exp_we(input logic [7:0] a, input logic open);
        int c;
        c = classify(a);
        if (c == 0) return 1'b1;
        if (c == 1) return open;
        return 1'b0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d, input string req);
        int c;
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        #1;
        chk(req, 32'(rf_we), 32'(exp_we(a, m_open)));
        if (exp_we(a, m_open)) begin
            chk(req, 32'(rf_addr), 32'(a));
            chk(req, rf_wdata, d);
        end
        @(posedge clk);
        c = classify(a);
        if (c == 2) begin
            m_ka = d;
            if (d != KA) m_open = 1'b0;
        end else if (c == 3) begin
            m_kb = d;
            if (d != KB) m_open = 1'b0;
            else if (m_ka == KA) m_open = 1'b1;
        end
        #1 bus_we = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, input string req);
        logic [31:0] exp;
        int c;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a; rf_rdata = $urandom;
        #1;
        c = classify(a);
        exp = (c == 2) ? m_ka : (c == 3) ? m_kb : rf_rdata;
        chk(req, bus_rdata, exp);
    endtask

    // Probes lock state through a guarded write that is withdrawn before the edge.
    task automatic probe(input logic expect_open, input string req);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h1;
        #1;
        chk(req, 32'(rf_we), 32'(expect_open));
        bus_we = 1'b0;
    endtask

    function automatic logic [31:0] pick_key(input logic [31:0] good);
        int r;
        r = $urandom % 4;
        if (r < 2) return good;
        if (r == 2) return 32'h0;
        return $urandom;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        do_read(8'h6C, "R1 key A after reset");
        do_read(8'h70, "R1 key B after reset");
        probe(1'b0, "R1 closed after reset");

        // R6 / R10 while closed
        do_write(8'h08, 32'hDEAD_BEEF, "R6 guarded write dropped");
        do_read(8'h44, "R10 read while closed");
        // R8 unguarded while closed
        do_write(8'h40, 32'h0000_0081, "R8 plain write while closed");
        // R2 key writes carry no strobe
        do_write(8'h6C, 32'h1234_5678, "R2 key A store no strobe");
        do_read(8'h6C, "R2 key A readback");
        // R4 wrong order
        do_write(8'h70, KB, "R4 key B first");
        probe(1'b0, "R4 still closed after B");
        do_write(8'h6C, KA, "R4 key A after B");
        probe(1'b0, "R4 still closed after late A");
        // R3 proper unlock
        do_write(8'h70, KB, "R3 key B completes unlock");
        probe(1'b1, "R3 open");
        do_write(8'h98, 32'hCAFE_0001, "R7 guarded write forwarded");
        do_read(8'h60, "R10 read while open");
        // R11 rewrite correct keys
        do_write(8'h6D, KA, "R11 rewrite A (low bits ignored)");
        probe(1'b1, "R11 still open after A");
        do_write(8'h70, KB, "R11 rewrite B");
        probe(1'b1, "R11 still open after B");
        // R8 plain write keeps state
        do_write(8'hFC, 32'h5, "R8 plain write while open");
        probe(1'b1, "R8 lock state unchanged");
        // R5 bad key / zero lock sequence
        do_write(8'h70, 32'h0, "R5 zero to B");
        probe(1'b0, "R5 closed after zero");
        do_write(8'h6C, 32'h0, "R5 zero to A");
        do_read(8'h70, "R2 key B reads zero");
        do_write(8'h6C, KA, "R5 reopen A");
        do_write(8'h70, KB, "R5 reopen B");
        do_write(8'h6C, 32'h83E7_0B12, "R5 near-miss A closes");
        probe(1'b0, "R5 closed after near-miss");

        // Random mix
        for (int i = 0; i < 800; i++) begin
            int r;
            r = $urandom % 10;
            case (r)
                0, 1: do_write(8'h6C, pick_key(KA), "R3 R5 random key A");
                2, 3: do_write(8'h70, pick_key(KB), "R3 R4 random key B");
                4, 5, 6: do_write(8'($urandom), $urandom, "R6 R7 R8 random write");
                7, 8: do_read(8'($urandom), "R10 random read");
                default: probe(m_open, "R3 R5 random probe");
            endcase
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule